// File: doc/BRIEF.md
# SIMT Divergence Stack Controller

This block steers one wavefront of 64 work-items that share a single program counter through divergent control flow. Upstream logic reports each resolved branch with its taken target, its fall-through address, the reconvergence address (the branch's immediate post-dominator, computed outside this block) and a per-lane taken mask. Upstream logic also reports the address of every instruction it fetches. The block keeps a stack of deferred paths and produces four registered outputs: the active lane mask, the next PC, a redirect strobe and an instruction-buffer flush strobe.

When the active lanes split at a branch, the taken side runs first. One stack entry records the fall-through address, the reconvergence address and the lanes that did not take the branch. When a fetch hits the reconvergence address on the stack top for the first time, the wavefront jumps to the deferred side with the deferred lanes. The same entry then records the union of both sides. The second hit pops that entry and restores the mask that was active before the split. The flush strobe fires only when the new PC is not the sequential successor, so continuations that happen to be sequential keep the buffer.

Top module: `simt_reconv_ctrl`

## Requirements
- R1: After a synchronous reset, exec_mask is all ones (bit i is lane i), next_pc is 0, redirect, ib_flush and overflow_err are 0, and the stack is empty.
- R2: A branch whose active lanes all appear in the taken mask pushes nothing. One cycle later next_pc is the target and redirect is 1. ib_flush is 1 only if the target differs from the fall-through address. The mask is unchanged.
- R3: A branch whose taken mask contains no active lane (set bits on inactive lanes do not count) sets next_pc to the fall-through address with no redirect, no flush and no mask change.
- R4: A branch where only some active lanes are taken pushes one entry holding {fall-through PC, reconvergence PC, active lanes not taken}. The mask becomes the taken active lanes, next_pc becomes the target and redirect is 1. ib_flush is 1 when the target differs from the fall-through.
- R5: A fetch whose PC equals the reconvergence PC of the stack top, on its first hit, sets next_pc to the saved fall-through PC and the mask to the saved lanes, with redirect 1. ib_flush is 1 unless the saved PC equals fetch PC + 4.
- R6: The second fetch hit on the same top entry pops it. The mask returns to the mask active before that split, next_pc is fetch PC + 4, and there is no redirect or flush.
- R7: A branch whose target equals the reconvergence PC of the stack top is treated as falling through. next_pc is the fall-through, with no push, no redirect, no flush and no mask change.
- R8: A fetch that does not match the stack top sets next_pc to fetch PC + 4 with both strobes low. In a cycle with no event, next_pc and the mask hold and both strobes are low.
- R9: Divergences nest. An inner pop restores the mask of the enclosing path, and after the outermost pop the mask equals the mask in use before the outermost split.
- R10: A split branch that arrives when 16 entries are already held sets overflow_err. The branch is then dropped (no push, mask unchanged, next_pc is the fall-through, no redirect). overflow_err stays set until reset.
- R11: When a branch event and a fetch arrive in the same cycle, the branch is handled and the fetch is ignored, so that fetch pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch has resolved this cycle |
| br_target | input | 32 | Taken-path address |
| br_fallthru | input | 32 | Not-taken (sequential) address |
| br_reconv | input | 32 | Reconvergence address of the branch |
| br_taken_mask | input | 64 | Per-lane taken bits, bit i is lane i |
| fetch_valid | input | 1 | An instruction is fetched this cycle |
| fetch_pc | input | 32 | Address of the fetched instruction |
| exec_mask | output | 64 | Active lane mask |
| next_pc | output | 32 | PC the wavefront continues from |
| redirect | output | 1 | One-cycle pulse: next_pc comes from a branch target or stack entry |
| ib_flush | output | 1 | One-cycle pulse: instruction buffer must be discarded |
| overflow_err | output | 1 | Sticky: a split was dropped because the stack was full |

## Verification
Every output is a register loaded at the clock edge that captures the event. The mask, PC, strobes and error flag for a branch or fetch are therefore due in the cycle right after that edge. Strobes fall back to zero one cycle later unless a new event arrives. The bench drives each event for one cycle and queues the expected output set for that cycle. A monitor pops and compares one set per clock, one time unit after the edge, so every result is checked exactly at the edge where it should first appear. Idle cycles are queued as well, which checks that state holds and that the pulses last one cycle.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;

  // Classification of a resolved branch against the current lane mask.
  typedef enum logic [2:0] {
    BR_IDLE,       // no branch this cycle
    BR_SKIP_RPC,   // target is the pending reconvergence point: fall through
    BR_ALL_NOT,    // no active lane takes the branch
    BR_ALL_TAKEN,  // every active lane takes it
    BR_SPLIT,      // lanes disagree, a deferred path is stacked
    BR_FULL        // lanes disagree but no room is left
  } br_kind_e;

  // Classification of a fetch against the stack top.
  typedef enum logic [1:0] {
    FT_IDLE,       // no fetch considered
    FT_SEQ,        // plain sequential fetch
    FT_SWITCH,     // first arrival at reconvergence: run deferred lanes
    FT_JOIN        // second arrival: pop and restore
  } ft_kind_e;

endpackage

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic         upd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // Entry storage: no reset, single write port, so distributed RAM fits.
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] top_idx;
  logic [AW-1:0] wr_idx;

  assign top_idx = AW'(cnt_q - ONE);
  assign wr_idx  = push ? AW'(cnt_q) : top_idx;

  always_ff @(posedge clk) begin
    if (push || upd) begin
      mem[wr_idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push) begin
      cnt_q <= cnt_q + ONE;
    end else if (pop) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign top   = mem[top_idx];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == FULL);

  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (pop || upd) |-> !empty);
  assert_push_grows_R4: assert property (@(posedge clk) disable iff (rst)
    push |=> (cnt_q == $past(cnt_q) + ONE));
  assert_pop_shrinks_R6: assert property (@(posedge clk) disable iff (rst)
    pop |=> (cnt_q == $past(cnt_q) - ONE));
  assert_one_op_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push, pop, upd}));

endmodule

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
  import simt_reconv_pkg::*;
#(
  parameter int LANES = 64,
  parameter int PCW   = 32
) (
  input  logic             valid,
  input  logic [PCW-1:0]   target,
  input  logic [LANES-1:0] taken_mask,
  input  logic [LANES-1:0] cur_mask,
  input  logic             stk_empty,
  input  logic             stk_full,
  input  logic [PCW-1:0]   top_rpc,
  output br_kind_e         kind,
  output logic [LANES-1:0] act_taken,
  output logic [LANES-1:0] act_not
);
  assign act_taken = taken_mask & cur_mask;
  assign act_not   = cur_mask & ~taken_mask;

  always_comb begin
    if (!valid) begin
      kind = BR_IDLE;
    end else if (!stk_empty && (target == top_rpc)) begin
      kind = BR_SKIP_RPC;
    end else if (act_taken == '0) begin
      kind = BR_ALL_NOT;
    end else if (act_taken == cur_mask) begin
      kind = BR_ALL_TAKEN;
    end else if (stk_full) begin
      kind = BR_FULL;
    end else begin
      kind = BR_SPLIT;
    end
  end

endmodule

// File: rtl/simt_fetch_eval.sv
module simt_fetch_eval
  import simt_reconv_pkg::*;
#(
  parameter int PCW  = 32,
  parameter int STEP = 4
) (
  input  logic           valid,
  input  logic [PCW-1:0] fetch_pc,
  input  logic           stk_empty,
  input  logic [PCW-1:0] top_rpc,
  input  logic           top_phase,
  output ft_kind_e       kind,
  output logic [PCW-1:0] seq_pc
);
  assign seq_pc = fetch_pc + PCW'(STEP);

  always_comb begin
    if (!valid) begin
      kind = FT_IDLE;
    end else if (!stk_empty && (fetch_pc == top_rpc)) begin
      kind = top_phase ? FT_JOIN : FT_SWITCH;
    end else begin
      kind = FT_SEQ;
    end
  end

endmodule

// File: rtl/simt_reconv_ctrl.sv
module simt_reconv_ctrl
  import simt_reconv_pkg::*;
#(
  parameter int LANES = 64,
  parameter int PCW   = 32,
  parameter int DEPTH = 16,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_valid,
  input  logic [PCW-1:0]   br_target,
  input  logic [PCW-1:0]   br_fallthru,
  input  logic [PCW-1:0]   br_reconv,
  input  logic [LANES-1:0] br_taken_mask,
  input  logic             fetch_valid,
  input  logic [PCW-1:0]   fetch_pc,
  output logic [LANES-1:0] exec_mask,
  output logic [PCW-1:0]   next_pc,
  output logic             redirect,
  output logic             ib_flush,
  output logic             overflow_err
);
  // phase 0: deferred lanes not yet run; phase 1: mask holds the union.
  typedef struct packed {
    logic             phase;
    logic [LANES-1:0] mask;
    logic [PCW-1:0]   rpc;
    logic [PCW-1:0]   div;
  } stk_ent_t;
  localparam int EW = $bits(stk_ent_t);

  logic [LANES-1:0] mask_q, mask_n;
  logic [PCW-1:0]   pc_q, pc_n;
  logic             redir_q, redir_n;
  logic             flush_q, flush_n;
  logic             err_q, err_set;

  logic             push, pop, upd;
  stk_ent_t         wr_e, top_e;
  logic [EW-1:0]    top_raw;
  logic             stk_empty, stk_full;

  br_kind_e         bk;
  ft_kind_e         fk;
  logic [LANES-1:0] act_taken, act_not;
  logic [PCW-1:0]   seq_pc;

  assign top_e = stk_ent_t'(top_raw);

  simt_reconv_stack #(.DEPTH(DEPTH), .W(EW)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .upd   (upd),
    .wdata (wr_e),
    .top   (top_raw),
    .empty (stk_empty),
    .full  (stk_full)
  );

  simt_branch_eval #(.LANES(LANES), .PCW(PCW)) u_br (
    .valid      (br_valid),
    .target     (br_target),
    .taken_mask (br_taken_mask),
    .cur_mask   (mask_q),
    .stk_empty  (stk_empty),
    .stk_full   (stk_full),
    .top_rpc    (top_e.rpc),
    .kind       (bk),
    .act_taken  (act_taken),
    .act_not    (act_not)
  );

  // A branch in the same cycle wins; the fetch is not considered.
  simt_fetch_eval #(.PCW(PCW), .STEP(STEP)) u_ft (
    .valid     (fetch_valid && !br_valid),
    .fetch_pc  (fetch_pc),
    .stk_empty (stk_empty),
    .top_rpc   (top_e.rpc),
    .top_phase (top_e.phase),
    .kind      (fk),
    .seq_pc    (seq_pc)
  );

  always_comb begin
    mask_n  = mask_q;
    pc_n    = pc_q;
    redir_n = 1'b0;
    flush_n = 1'b0;
    err_set = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    upd     = 1'b0;
    wr_e    = top_e;
    unique case (bk)
      BR_SKIP_RPC, BR_ALL_NOT: begin
        pc_n = br_fallthru;
      end
      BR_ALL_TAKEN: begin
        pc_n    = br_target;
        redir_n = 1'b1;
        flush_n = (br_target != br_fallthru);
      end
      BR_FULL: begin
        pc_n    = br_fallthru;
        err_set = 1'b1;
      end
      BR_SPLIT: begin
        push       = 1'b1;
        wr_e.phase = 1'b0;
        wr_e.mask  = act_not;
        wr_e.rpc   = br_reconv;
        wr_e.div   = br_fallthru;
        mask_n     = act_taken;
        pc_n       = br_target;
        redir_n    = 1'b1;
        flush_n    = (br_target != br_fallthru);
      end
      default: begin
        unique case (fk)
          FT_SEQ: begin
            pc_n = seq_pc;
          end
          FT_SWITCH: begin
            upd        = 1'b1;
            wr_e.phase = 1'b1;
            wr_e.mask  = top_e.mask | mask_q;
            mask_n     = top_e.mask;
            pc_n       = top_e.div;
            redir_n    = 1'b1;
            flush_n    = (top_e.div != seq_pc);
          end
          FT_JOIN: begin
            pop    = 1'b1;
            mask_n = top_e.mask;
            pc_n   = seq_pc;
          end
          default: begin
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      pc_q    <= '0;
      redir_q <= 1'b0;
      flush_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      mask_q  <= mask_n;
      pc_q    <= pc_n;
      redir_q <= redir_n;
      flush_q <= flush_n;
      err_q   <= err_q | err_set;
    end
  end

  assign exec_mask    = mask_q;
  assign next_pc      = pc_q;
  assign redirect     = redir_q;
  assign ib_flush     = flush_q;
  assign overflow_err = err_q;

  assert_flush_has_redirect_R2: assert property (@(posedge clk) disable iff (rst)
    ib_flush |-> redirect);
  assert_mask_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
    exec_mask != '0);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overflow_err |=> overflow_err);
  assert_split_narrows_R4: assert property (@(posedge clk) disable iff (rst)
    (bk == BR_SPLIT) |=> (redirect &&
      exec_mask == ($past(exec_mask) & $past(br_taken_mask))));
  assert_not_taken_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (bk == BR_ALL_NOT) |=> (!redirect && !ib_flush &&
      next_pc == $past(br_fallthru) && $stable(exec_mask)));
  assert_full_drops_R10: assert property (@(posedge clk) disable iff (rst)
    (bk == BR_FULL) |=> (overflow_err && !redirect && $stable(exec_mask)));
  assert_join_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (fk == FT_JOIN) |=> (!redirect && !ib_flush));

endmodule

// File: tb/simt_reconv_ctrl_bench.sv
`timescale 1ns/1ps
module simt_reconv_ctrl_bench;
  localparam int LN = 64;
  localparam int PW = 32;
  localparam int DP = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          br_valid = 1'b0;
  logic [PW-1:0] br_target = '0, br_fallthru = '0, br_reconv = '0;
  logic [LN-1:0] br_taken_mask = '0;
  logic          fetch_valid = 1'b0;
  logic [PW-1:0] fetch_pc = '0;
  logic [LN-1:0] exec_mask;
  logic [PW-1:0] next_pc;
  logic          redirect, ib_flush, overflow_err;

  always #2.5 clk = ~clk;

  simt_reconv_ctrl u_simt_reconv_ctrl (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_target(br_target),
    .br_fallthru(br_fallthru), .br_reconv(br_reconv),
    .br_taken_mask(br_taken_mask), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .exec_mask(exec_mask), .next_pc(next_pc),
    .redirect(redirect), .ib_flush(ib_flush), .overflow_err(overflow_err)
  );

  int checks = 0;
  int fails  = 0;

  // Scoreboard queues, one element per clock.
  logic [LN-1:0] q_mask[$];
  logic [PW-1:0] q_pc[$];
  bit            q_rd[$], q_fl[$], q_er[$];
  string         q_tag[$];

  // Requirement-level model state.
  logic [LN-1:0] m_mask;
  logic [PW-1:0] m_pc;
  bit            m_err;
  logic [PW-1:0] s_div[DP], s_rpc[DP];
  logic [LN-1:0] s_mask[DP];
  bit            s_ph[DP];
  int            s_cnt;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: one time unit after each edge, compare the due results.
  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      logic [LN-1:0] em;
      logic [PW-1:0] ep;
      bit er, ef, ee;
      string t;
      em = q_mask.pop_front(); ep = q_pc.pop_front();
      er = q_rd.pop_front();   ef = q_fl.pop_front();
      ee = q_er.pop_front();   t  = q_tag.pop_front();
      check(exec_mask == em, t, "exec_mask", exec_mask, em);
      check(next_pc == ep, t, "next_pc", 64'(next_pc), 64'(ep));
      check(redirect == er, t, "redirect", 64'(redirect), 64'(er));
      check(ib_flush == ef, t, "ib_flush", 64'(ib_flush), 64'(ef));
      check(overflow_err == ee, t, "overflow_err", 64'(overflow_err), 64'(ee));
    end
  end

  task automatic model_reset();
    m_mask = '1; m_pc = '0; m_err = 0; s_cnt = 0;
  endtask

  // Driver: called at a falling edge; predicts and drives one cycle.
  task automatic step(input string tag, input bit bv, input logic [PW-1:0] tgt,
                      input logic [PW-1:0] fall, input logic [PW-1:0] rpc,
                      input logic [LN-1:0] tm, input bit fv,
                      input logic [PW-1:0] fpc);
    logic [LN-1:0] act, nm;
    logic [PW-1:0] seq;
    bit rd, fl;
    rd = 0; fl = 0;
    act = tm & m_mask;
    seq = fpc + 32'd4;
    if (bv) begin
      if (s_cnt > 0 && tgt == s_rpc[s_cnt-1]) m_pc = fall;
      else if (act == '0) m_pc = fall;
      else if (act == m_mask) begin m_pc = tgt; rd = 1; fl = (tgt != fall); end
      else if (s_cnt == DP) begin m_pc = fall; m_err = 1; end
      else begin
        s_div[s_cnt] = fall; s_rpc[s_cnt] = rpc;
        s_mask[s_cnt] = m_mask & ~tm; s_ph[s_cnt] = 0; s_cnt++;
        m_mask = act; m_pc = tgt; rd = 1; fl = (tgt != fall);
      end
    end else if (fv) begin
      if (s_cnt > 0 && fpc == s_rpc[s_cnt-1]) begin
        if (!s_ph[s_cnt-1]) begin
          nm = s_mask[s_cnt-1];
          s_mask[s_cnt-1] = nm | m_mask; s_ph[s_cnt-1] = 1;
          m_mask = nm; m_pc = s_div[s_cnt-1]; rd = 1;
          fl = (s_div[s_cnt-1] != seq);
        end else begin
          m_mask = s_mask[s_cnt-1]; s_cnt--; m_pc = seq;
        end
      end else m_pc = seq;
    end
    q_mask.push_back(m_mask); q_pc.push_back(m_pc); q_rd.push_back(rd);
    q_fl.push_back(fl); q_er.push_back(m_err); q_tag.push_back(tag);
    br_valid = bv; br_target = tgt; br_fallthru = fall; br_reconv = rpc;
    br_taken_mask = tm; fetch_valid = fv; fetch_pc = fpc;
    @(negedge clk);
    br_valid = 0; fetch_valid = 0;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, '0, '0, '0, '0, 0, '0);
  endtask
  task automatic br(input string tag, input logic [PW-1:0] tgt,
                    input logic [PW-1:0] fall, input logic [PW-1:0] rpc,
                    input logic [LN-1:0] tm);
    step(tag, 1, tgt, fall, rpc, tm, 0, '0);
  endtask
  task automatic fetch(input string tag, input logic [PW-1:0] fpc);
    step(tag, 0, '0, '0, '0, '0, 1, fpc);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    model_reset();
    rst = 0;
  endtask

  initial begin
    #(5ns * 200000);
    fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    idle("R1 reset state");
    idle("R1 reset hold");
    fetch("R8 plain fetch", 32'h100);
    idle("R8 idle holds, strobes drop");
    br("R2 uniform taken jump", 32'h200, 32'h104, 32'h900, '1);
    br("R2 uniform taken sequential", 32'h108, 32'h108, 32'h900, '1);
    br("R3 uniform not taken", 32'h300, 32'h10C, 32'h900, '0);
    // Outer split, low half taken.
    br("R4 split", 32'h300, 32'h204, 32'h400, 64'h0000_0000_FFFF_FFFF);
    fetch("R8 fetch inside taken path", 32'h300);
    br("R7 target equals top rpc", 32'h400, 32'h308, 32'h800, '1);
    br("R3 taken bits only on idle lanes", 32'h700, 32'h30C, 32'h800,
       64'hFFFF_FFFF_0000_0000);
    // Nested split.
    br("R9 nested split", 32'h500, 32'h310, 32'h380, 64'h0000_0000_0000_FFFF);
    fetch("R5 inner switch", 32'h380);
    fetch("R6 inner join", 32'h380);
    fetch("R9 after inner join", 32'h384);
    fetch("R5 outer switch", 32'h400);
    step("R11 branch wins over fetch", 1, 32'h900, 32'h208, 32'h990, '0, 1, 32'h400);
    fetch("R9 outer join restores all", 32'h400);
    idle("R9 restored mask holds");
    // Deferred path that is the sequential successor.
    br("R4 split, second shape", 32'h600, 32'h504, 32'h500, 64'hAAAA_AAAA_AAAA_AAAA);
    fetch("R5 switch to sequential successor", 32'h500);
    fetch("R6 join after sequential switch", 32'h500);
    // Fill the stack, then overflow.
    for (int k = 0; k < DP; k++) begin
      br("R10 fill stack", 32'h2000 + 32'(k) * 32'h40, 32'h1004 + 32'(k) * 32'h40,
         32'h8000 + 32'(k) * 32'h10, ~(64'd1 << k));
    end
    br("R10 overflow drops split", 32'h7000, 32'h7004, 32'h9000,
       64'h0000_0000_0000_0001 << 20);
    idle("R10 error sticky");
    fetch("R10 error sticky after fetch", 32'h3000);
    fetch("R5 switch at top of full stack", 32'h80F0);
    do_reset();
    idle("R1 reset clears error");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule